// File: doc/BRIEF.md
# SPI Frame-Count Transfer Sequencer

This block sits between a transmit queue, a receive queue and the serial pins of an SPI controller. While the controller is enabled, it takes one word at a time from the transmit queue and shifts it out on the data-out pin. It shifts the answering bits in from the data-in pin and hands each received frame to the receive queue. It drives the active-low chip select and counts frames toward a programmed burst length. When the burst length is used up, it raises the transmit-done and receive-ready events.

Two modes govern chip select. In pulse mode, select is released after every frame. In hold mode, select stays low from the first frame of a burst until the last frame of that burst has finished, even if the transmit queue runs dry in between. The frame size can be any value from 1 to 32 bits and is set through a guarded write. The serial clock is a divided copy of the system clock.

Register decode is not part of this block. The burst length arrives as the already-extracted 16-bit count field (bits 23:8 of the control word) together with a write strobe. The raw-event clear arrives as a two-bit strobe.

Top module: `spi_burst_seq`

## Requirements
- R1: A frame starts (`tx_pop_o` high for exactly one cycle, capturing `tx_data_i` at that edge) only when `enable_i` is 1, `tx_empty_i` is 0 and the remaining frame count is non-zero. While the count is zero, or while the block is disabled, no word is taken.
- R2: `cs_n_o` goes low in the cycle after `tx_pop_o` and stays low for the whole frame.
- R3: With `hold_sel_i` = 0, `cs_n_o` returns high in the cycle after `rx_push_o`. With `hold_sel_i` = 1, it stays low after a frame that does not end the burst, including while the transmit queue is empty.
- R4: The status outputs `tx_done_o` and `rx_rdy_o` are cleared when a frame starts.
- R5: `frames_left_o` drops by one after each frame. When a frame ends with a count of 1, the following happen together: the count reloads from the last written burst length, `cs_n_o` goes high, and `tx_done_o`, `rx_rdy_o`, `tx_done_raw_o` and `rx_rdy_raw_o` all go to 1.
- R6: A `burst_len_wr_i` pulse loads `burst_len_i` into both the frame counter and the reload value. `frames_left_o` shows the new value in the next cycle.
- R7: A `fsize_wr_i` pulse is accepted only when `enable_i` is 0 and `fsize_i` lies between 1 and 32. Any other write leaves `fsize_o` unchanged.
- R8: After reset: `frames_left_o` = 1, `fsize_o` = 4, `cs_n_o` = 1, `sclk_o` = 0, all four event outputs are 0, and `tx_pop_o` = 0.
- R9: A frame of N bits sends bits N-1 down to 0 of the transmit word, most significant first. The received bits are right-aligned in `rx_data_o` with zeros above bit N-1, and the word is valid during the one-cycle `rx_push_o` pulse.
- R10: `sclk_o` idles low and has a period of 2×(`div_i`+1) system clocks during a frame. `mosi_o` changes only on falling edges, and `miso_i` is sampled on rising edges.
- R11: `raw_clr_i` bit 0 clears `tx_done_raw_o` and bit 1 clears `rx_rdy_raw_o`. The status outputs are unaffected by the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Controller enable; frames start only while high |
| hold_sel_i | input | 1 | 1 keeps chip select low across the frames of a burst |
| burst_len_wr_i | input | 1 | Write strobe for the burst length |
| burst_len_i | input | 16 | Burst length (frames per burst) |
| fsize_wr_i | input | 1 | Write strobe for the frame size |
| fsize_i | input | 6 | Requested frame size in bits |
| div_i | input | 8 | Serial clock divider |
| tx_empty_i | input | 1 | Transmit queue is empty |
| tx_data_i | input | 32 | Head word of the transmit queue |
| tx_pop_o | output | 1 | Take the head word of the transmit queue |
| rx_push_o | output | 1 | Write `rx_data_o` into the receive queue |
| rx_data_o | output | 32 | Received frame, right-aligned |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low chip select |
| raw_clr_i | input | 2 | Clear strobes for the raw events (bit 0 transmit, bit 1 receive) |
| tx_done_o | output | 1 | Transmit-done status |
| rx_rdy_o | output | 1 | Receive-ready status |
| tx_done_raw_o | output | 1 | Latched transmit-done raw event |
| rx_rdy_raw_o | output | 1 | Latched receive-ready raw event |
| frames_left_o | output | 16 | Frames remaining in the current burst |
| fsize_o | output | 6 | Frame size in use |

## Verification
The assertions assume three things about the inputs. First, `div_i` does not change while a frame is shifting. Second, `tx_data_i` holds the head word whenever `tx_empty_i` is low. Third, the counter checks look only at cycles without a burst-length write. The stimulus respects all three: the divider, frame size, hold mode and burst length are reprogrammed only while the block is disabled between bursts, and the bench's queue model changes its head only after the edge that consumed it. Data-in is looped back from data-out, either straight or inverted, so the received word can be predicted. Burst lengths, frame sizes, dividers and word counts are drawn at random, and directed cases cover a zero count, a disabled block, 1-bit and 32-bit frames, and rejected size writes.

// File: rtl/spi_burst_pkg.sv
// Shared definitions for the SPI burst sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package spi_burst_pkg;

    // Frame-level state of the burst controller.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_XFER = 1'b1
    } seq_state_e;

    // Bit positions inside the raw-event clear strobe.
    localparam int RAW_TX_BIT = 0;
    localparam int RAW_RX_BIT = 1;

endpackage

// File: rtl/spi_sclk_div.sv
// Serial clock tick generator: pulses tick_o once every div_i+1 cycles
// while run_i is high; the shifter toggles SCLK on each tick.
// Assumes div_i is stable while run_i is high.
module spi_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap_w;

    assign wrap_w = (cnt_q >= div_i);
    assign tick_o = run_i && wrap_w;

    // Half-period counter, held at zero while no frame is shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (wrap_w) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && $past(run_i) && $stable(div_i) |-> cnt_q <= div_i);

endmodule

// File: rtl/spi_frame_shifter.sv
// One-frame SPI shifter (clock idle low, sample on rising, shift on falling).
// Loads the low fsize_i bits of the word MSB-aligned, shifts out MSB first,
// collects fsize_i input bits right-aligned, then pulses done_o.
// Assumes fsize_i is 1..DATA_W at start_i and start_i only when not busy.
module spi_frame_shifter #(
    parameter int DATA_W  = 32,
    parameter int FSIZE_W = $clog2(DATA_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DATA_W-1:0]  tx_word_i,
    input  logic [FSIZE_W-1:0] fsize_i,
    input  logic               tick_i,
    input  logic               miso_i,
    output logic               busy_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  rx_word_o
);

    localparam int SH_W = FSIZE_W + 1;

    logic [DATA_W-1:0]  sreg_q;
    logic [DATA_W-1:0]  rreg_q;
    logic [FSIZE_W-1:0] bits_q;
    logic [SH_W-1:0]    lsh_w;
    logic               busy_q;
    logic               sclk_q;
    logic               done_q;

    assign lsh_w     = SH_W'(DATA_W) - SH_W'(fsize_i);
    assign busy_o    = busy_q;
    assign sclk_o    = sclk_q;
    assign mosi_o    = sreg_q[DATA_W-1];
    assign done_o    = done_q;

    // Frame engine: load, toggle SCLK on ticks, sample, shift, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q    <= '0;
            rreg_q    <= '0;
            bits_q    <= '0;
            busy_q    <= 1'b0;
            sclk_q    <= 1'b0;
            done_q    <= 1'b0;
            rx_word_o <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                sreg_q <= tx_word_i << lsh_w;
                rreg_q <= '0;
                bits_q <= fsize_i;
                sclk_q <= 1'b0;
                busy_q <= 1'b1;
            end else if (busy_q && tick_i) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rreg_q <= {rreg_q[DATA_W-2:0], miso_i};
                    bits_q <= bits_q - 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    sreg_q <= sreg_q << 1;
                    if (bits_q == '0) begin
                        busy_q    <= 1'b0;
                        done_q    <= 1'b1;
                        rx_word_o <= rreg_q;
                    end
                end
            end
        end
    end

    p_sclk_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);

    p_mosi_steady_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_q && $past(sclk_q) |-> $stable(mosi_o));

    p_bits_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> bits_q <= FSIZE_W'(DATA_W));

endmodule

// File: rtl/spi_fsize_reg.sv
// Frame size holder: accepts a write only while disabled and in 1..DATA_W.
// Assumes the writer does not need an error indication.
module spi_fsize_reg #(
    parameter int DATA_W    = 32,
    parameter int FSIZE_W   = $clog2(DATA_W + 1),
    parameter int RST_FSIZE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               wr_i,
    input  logic [FSIZE_W-1:0] val_i,
    output logic [FSIZE_W-1:0] fsize_o
);

    logic ok_w;

    assign ok_w = !en_i && (val_i != '0) && (val_i <= FSIZE_W'(DATA_W));

    // Guarded update of the frame size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsize_o <= FSIZE_W'(RST_FSIZE);
        end else if (wr_i && ok_w) begin
            fsize_o <= val_i;
        end
    end

    p_fsize_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fsize_o != '0 && fsize_o <= FSIZE_W'(DATA_W));

    p_fsize_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> $stable(fsize_o));

endmodule

// File: rtl/spi_burst_ctrl.sv
// Burst controller: launches frames, drives chip select, counts frames,
// reloads the count at burst end and raises the done/ready events.
// Assumes frame_done_i pulses once per launched frame.
module spi_burst_ctrl
    import spi_burst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             hold_i,
    input  logic             len_wr_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             tx_empty_i,
    input  logic             frame_done_i,
    input  logic [1:0]       raw_clr_i,
    output logic             launch_o,
    output logic             cs_n_o,
    output logic [CNT_W-1:0] frames_left_o,
    output logic             tx_done_o,
    output logic             rx_rdy_o,
    output logic             tx_done_raw_o,
    output logic             rx_rdy_raw_o
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] frames_q;
    logic [CNT_W-1:0] reload_q;
    logic             last_w;

    assign launch_o      = (state_q == SEQ_IDLE) && en_i && !tx_empty_i
                           && (frames_q != '0);
    assign last_w        = frame_done_i && (frames_q <= CNT_W'(1));
    assign frames_left_o = frames_q;

    // Frame state: idle until launch, busy until the shifter reports done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (launch_o) begin
            state_q <= SEQ_XFER;
        end else if (frame_done_i) begin
            state_q <= SEQ_IDLE;
        end
    end

    // Burst length: a write loads both counter and reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= CNT_W'(1);
            frames_q <= CNT_W'(1);
        end else if (len_wr_i) begin
            reload_q <= len_i;
            frames_q <= len_i;
        end else if (last_w) begin
            frames_q <= reload_q;
        end else if (frame_done_i) begin
            frames_q <= frames_q - 1'b1;
        end
    end

    // Chip select: low at each launch, released per frame or at burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o <= 1'b1;
        end else if (launch_o) begin
            cs_n_o <= 1'b0;
        end else if (frame_done_i && (last_w || !hold_i)) begin
            cs_n_o <= 1'b1;
        end
    end

    // Status events: cleared at launch, set at burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done_o <= 1'b0;
            rx_rdy_o  <= 1'b0;
        end else if (launch_o) begin
            tx_done_o <= 1'b0;
            rx_rdy_o  <= 1'b0;
        end else if (last_w) begin
            tx_done_o <= 1'b1;
            rx_rdy_o  <= 1'b1;
        end
    end

    // Raw events: set at burst end (wins), cleared by strobe bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done_raw_o <= 1'b0;
            rx_rdy_raw_o  <= 1'b0;
        end else if (last_w) begin
            tx_done_raw_o <= 1'b1;
            rx_rdy_raw_o  <= 1'b1;
        end else begin
            if (raw_clr_i[RAW_TX_BIT]) tx_done_raw_o <= 1'b0;
            if (raw_clr_i[RAW_RX_BIT]) rx_rdy_raw_o  <= 1'b0;
        end
    end

    p_cs_low_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SEQ_XFER |-> !cs_n_o);

    p_launch_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !launch_o);

    p_status_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !tx_done_o && !rx_rdy_o);

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_i && !len_wr_i && frames_q > CNT_W'(1)
        |=> frames_q == $past(frames_q) - 1'b1);

    p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_i && !len_wr_i && frames_q == CNT_W'(1)
        |=> frames_q == $past(reload_q) && cs_n_o && tx_done_o && rx_rdy_raw_o);

    p_len_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        len_wr_i |=> frames_q == $past(len_i));

endmodule

// File: rtl/spi_burst_seq.sv
// SPI frame-count transfer sequencer top: ties the burst controller,
// frame size holder, SCLK divider and frame shifter together.
// Assumes a first-word-fall-through transmit queue (tx_data_i valid while
// tx_empty_i is low) and a receive queue that always accepts rx_push_o.
module spi_burst_seq #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 8,
    parameter int RST_FSIZE = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable_i,
    input  logic                          hold_sel_i,
    input  logic                          burst_len_wr_i,
    input  logic [CNT_W-1:0]              burst_len_i,
    input  logic                          fsize_wr_i,
    input  logic [$clog2(DATA_W+1)-1:0]   fsize_i,
    input  logic [DIV_W-1:0]              div_i,
    input  logic                          tx_empty_i,
    input  logic [DATA_W-1:0]             tx_data_i,
    output logic                          tx_pop_o,
    output logic                          rx_push_o,
    output logic [DATA_W-1:0]             rx_data_o,
    output logic                          sclk_o,
    output logic                          mosi_o,
    input  logic                          miso_i,
    output logic                          cs_n_o,
    input  logic [1:0]                    raw_clr_i,
    output logic                          tx_done_o,
    output logic                          rx_rdy_o,
    output logic                          tx_done_raw_o,
    output logic                          rx_rdy_raw_o,
    output logic [CNT_W-1:0]              frames_left_o,
    output logic [$clog2(DATA_W+1)-1:0]   fsize_o
);

    localparam int FSIZE_W = $clog2(DATA_W + 1);

    logic launch_w;
    logic tick_w;
    logic busy_w;
    logic done_w;

    assign tx_pop_o  = launch_w;
    assign rx_push_o = done_w;

    spi_burst_ctrl #(
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (enable_i),
        .hold_i        (hold_sel_i),
        .len_wr_i      (burst_len_wr_i),
        .len_i         (burst_len_i),
        .tx_empty_i    (tx_empty_i),
        .frame_done_i  (done_w),
        .raw_clr_i     (raw_clr_i),
        .launch_o      (launch_w),
        .cs_n_o        (cs_n_o),
        .frames_left_o (frames_left_o),
        .tx_done_o     (tx_done_o),
        .rx_rdy_o      (rx_rdy_o),
        .tx_done_raw_o (tx_done_raw_o),
        .rx_rdy_raw_o  (rx_rdy_raw_o)
    );

    spi_fsize_reg #(
        .DATA_W    (DATA_W),
        .FSIZE_W   (FSIZE_W),
        .RST_FSIZE (RST_FSIZE)
    ) fsize_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (enable_i),
        .wr_i    (fsize_wr_i),
        .val_i   (fsize_i),
        .fsize_o (fsize_o)
    );

    spi_sclk_div #(
        .DIV_W (DIV_W)
    ) div_i_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_w),
        .div_i  (div_i),
        .tick_o (tick_w)
    );

    spi_frame_shifter #(
        .DATA_W  (DATA_W),
        .FSIZE_W (FSIZE_W)
    ) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (launch_w),
        .tx_word_i (tx_data_i),
        .fsize_i   (fsize_o),
        .tick_i    (tick_w),
        .miso_i    (miso_i),
        .busy_o    (busy_w),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .done_o    (done_w),
        .rx_word_o (rx_data_o)
    );

    p_frame_under_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> !cs_n_o);

    p_pop_starts_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |=> busy_w && !cs_n_o);

    p_push_ends_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_o |-> $past(busy_w) && !busy_w);

endmodule

// File: tb/spi_burst_seq_tb.sv
// Self-checking bench for spi_burst_seq: queue model for the transmit side,
// looped-back (optionally inverted) data-in, SCLK/MOSI observer.
module spi_burst_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        hold_sel_i = 1'b0;
    logic        burst_len_wr_i = 1'b0;
    logic [15:0] burst_len_i = '0;
    logic        fsize_wr_i = 1'b0;
    logic [5:0]  fsize_i = '0;
    logic [7:0]  div_i = '0;
    logic        tx_empty_i = 1'b1;
    logic [31:0] tx_data_i = '0;
    logic [1:0]  raw_clr_i = '0;
    logic        inv = 1'b0;
    logic        tx_pop_o, rx_push_o, sclk_o, mosi_o, miso_i, cs_n_o;
    logic        tx_done_o, rx_rdy_o, tx_done_raw_o, rx_rdy_raw_o;
    logic [31:0] rx_data_o;
    logic [15:0] frames_left_o;
    logic [5:0]  fsize_o;

    int n_checks = 0;
    int n_err = 0;

    // Monitor state
    logic [31:0] txq[$];
    bit          pop_pend = 0;
    int          pops_seen = 0;
    logic [31:0] cap = '0;
    int          ncap = 0;
    int          cyc = 0;
    int          last_rise = -1;
    int          period = 0;
    logic        sclk_prev = 1'b0;

    always #10 clk = ~clk;

    assign miso_i = mosi_o ^ inv;

    spi_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .hold_sel_i(hold_sel_i),
        .burst_len_wr_i(burst_len_wr_i), .burst_len_i(burst_len_i),
        .fsize_wr_i(fsize_wr_i), .fsize_i(fsize_i), .div_i(div_i),
        .tx_empty_i(tx_empty_i), .tx_data_i(tx_data_i), .tx_pop_o(tx_pop_o),
        .rx_push_o(rx_push_o), .rx_data_o(rx_data_o), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o), .raw_clr_i(raw_clr_i),
        .tx_done_o(tx_done_o), .rx_rdy_o(rx_rdy_o), .tx_done_raw_o(tx_done_raw_o),
        .rx_rdy_raw_o(rx_rdy_raw_o), .frames_left_o(frames_left_o), .fsize_o(fsize_o)
    );

    function automatic void refresh();
        tx_empty_i = (txq.size() == 0);
        tx_data_i  = (txq.size() == 0) ? 32'h0 : txq[0];
    endfunction

    function automatic logic [31:0] fmask(input int n);
        logic [63:0] one = 64'd1;
        return 32'((one << n) - 64'd1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Queue model, pop tracking and SCLK/MOSI observation away from the edge.
    always @(negedge clk) begin
        if (pop_pend) begin
            void'(txq.pop_front());
            refresh();
        end
        pop_pend = tx_pop_o;
        cyc++;
        if (tx_pop_o) begin
            pops_seen++;
            cap = '0; ncap = 0; last_rise = -1; period = 0;
        end
        if (sclk_o && !sclk_prev) begin
            cap = {cap[30:0], mosi_o};
            ncap++;
            if (last_rise >= 0 && period == 0) period = cyc - last_rise;
            last_rise = cyc;
        end
        sclk_prev = sclk_o;
    end

    task automatic wait_push(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (rx_push_o === 1'b1) begin ok = 1; break; end
        end
    endtask

    task automatic configure(input int cnt, input bit hold, input int fsz, input int dv);
        @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        fsize_wr_i = 1'b1; fsize_i = 6'(fsz);
        burst_len_wr_i = 1'b1; burst_len_i = 16'(cnt);
        hold_sel_i = hold; div_i = 8'(dv);
        @(negedge clk);
        fsize_wr_i = 1'b0; burst_len_wr_i = 1'b0;
        enable_i = 1'b1;
    endtask

    task automatic run_burst(input int cnt, input bit hold, input int fsz,
                             input int dv, input int nw, input bit inv_b);
        logic [31:0] words[$];
        int  left = cnt;
        bit  ended = 0;
        bit  ok;
        logic [31:0] m = fmask(fsz);
        inv = inv_b;
        configure(cnt, hold, fsz, dv);
        chk("R7 fsize accepted", 32'(fsize_o), 32'(fsz));
        for (int i = 0; i < nw; i++) begin
            words.push_back($urandom);
            txq.push_back(words[i]);
        end
        refresh();
        for (int k = 0; k < nw; k++) begin
            wait_push(ok);
            chk("R1 frame completed", 32'(ok), 32'd1);
            if (!ok) return;
            chk("R9 rx right-aligned", rx_data_o, (inv_b ? ~words[k] : words[k]) & m);
            chk("R9 mosi msb first", cap, words[k] & m);
            chk("R10 rising edge count", 32'(ncap), 32'(fsz));
            if (k == 0 && fsz >= 2) chk("R10 sclk period", 32'(period), 32'(2 * (dv + 1)));
            @(negedge clk);
            ended = (left == 1);
            left  = ended ? cnt : left - 1;
            chk("R5 frames left", 32'(frames_left_o), 32'(left));
            chk("R3 cs after frame", 32'(cs_n_o), 32'((ended || !hold) ? 1 : 0));
            if (ended) begin
                chk("R5 done status", {30'd0, tx_done_o, rx_rdy_o}, 32'd3);
                chk("R5 done raw", {30'd0, tx_done_raw_o, rx_rdy_raw_o}, 32'd3);
            end else begin
                chk("R4 status cleared", {30'd0, tx_done_o, rx_rdy_o}, 32'd0);
            end
        end
        repeat (20) @(negedge clk);
        chk("R3 cs idle state", 32'(cs_n_o), 32'((hold && !ended) ? 0 : 1));
    endtask

    task automatic clear_raw();
        logic st;
        st = tx_done_o;
        @(negedge clk); raw_clr_i = 2'b01;
        @(negedge clk); raw_clr_i = 2'b10;
        chk("R11 tx raw cleared", 32'(tx_done_raw_o), 32'd0);
        @(negedge clk); raw_clr_i = 2'b00;
        chk("R11 rx raw cleared", 32'(rx_rdy_raw_o), 32'd0);
        chk("R11 status kept", 32'(tx_done_o), 32'(st));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        int p0;
        void'($urandom(32'h0000_5EED));
        refresh();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 frames_left", 32'(frames_left_o), 32'd1);
        chk("R8 fsize", 32'(fsize_o), 32'd4);
        chk("R8 cs_n", 32'(cs_n_o), 32'd1);
        chk("R8 sclk", 32'(sclk_o), 32'd0);
        chk("R8 events", {28'd0, tx_done_o, rx_rdy_o, tx_done_raw_o, rx_rdy_raw_o}, 32'd0);
        chk("R8 no pop", 32'(tx_pop_o), 32'd0);

        // R1: disabled block takes nothing
        txq.push_back(32'hA5A5_0001); refresh();
        p0 = pops_seen;
        repeat (30) @(negedge clk);
        chk("R1 disabled no pop", 32'(pops_seen - p0), 32'd0);
        // R1: zero count takes nothing
        configure(0, 0, 8, 0);
        chk("R6 zero length loaded", 32'(frames_left_o), 32'd0);
        repeat (30) @(negedge clk);
        chk("R1 zero count no pop", 32'(pops_seen - p0), 32'd0);
        chk("R1 queue untouched", 32'(txq.size()), 32'd1);
        enable_i = 1'b0;
        txq.delete(); refresh();

        // R7: illegal or locked size writes
        configure(2, 0, 12, 0);
        enable_i = 1'b0;
        foreach (p0_list[i]) ;
        @(negedge clk); fsize_wr_i = 1'b1; fsize_i = 6'd33;
        @(negedge clk); fsize_i = 6'd0;
        @(negedge clk); fsize_i = 6'd63;
        @(negedge clk); fsize_wr_i = 1'b0;
        chk("R7 rejected out of range", 32'(fsize_o), 32'd12);
        enable_i = 1'b1;
        @(negedge clk); fsize_wr_i = 1'b1; fsize_i = 6'd20;
        @(negedge clk); fsize_wr_i = 1'b0;
        chk("R7 locked while enabled", 32'(fsize_o), 32'd12);

        // R6: length write reloads counter
        @(negedge clk); burst_len_wr_i = 1'b1; burst_len_i = 16'd7;
        @(negedge clk); burst_len_wr_i = 1'b0;
        chk("R6 length loaded", 32'(frames_left_o), 32'd7);

        // Directed corners: 1-bit and 32-bit frames, hold with dry queue
        run_burst(2, 0, 1, 0, 2, 1);
        clear_raw();
        run_burst(3, 1, 32, 0, 2, 0);
        run_burst(1, 1, 32, 2, 3, 1);
        clear_raw();

        // Random bursts
        for (int r = 0; r < 14; r++) begin
            run_burst(1 + int'($urandom % 4), bit'($urandom % 2),
                      1 + int'($urandom % 32), int'($urandom % 3),
                      1 + int'($urandom % 6), bit'($urandom % 2));
            if (r % 4 == 3) clear_raw();
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    int p0_list[1];

endmodule